// File: doc/BRIEF.md
# Tracking-Error Health Monitor

This block watches a tracking angle converter and drives a single active-low health flag. It reads a signed tracking error, the digitised peak amplitudes of the sine, cosine and reference channels, and a two-bit resolution code. The flag drops low in three cases. The first is a tracking error that stays too large for a qualification window. The second is both signal channels going quiet at the same time. The third is the reference going quiet.

The tracking error is supplied in LSBs of the finest (16-bit) scale. The resolution code scales the fault threshold so that it always equals `ERR_LIMIT` LSBs of the active resolution. A coarser resolution therefore tolerates a proportionally larger raw error.

The qualification window counts a sample-rate tick. The window length is a parameter, so a designer can size it to about half a millisecond for a given tick rate. Amplitude faults bypass the window and act on the flag in the same cycle. Once the loop settles, the flag recovers without any outside action.

Top module: `trk_bit_monitor`

## Requirements
- R1: `health_n` is active low, where 1 means healthy. While reset is held, and after reset with adequate amplitudes and zero error, `health_n` is 1.
- R2: The error threshold, in finest-scale LSBs, depends on `res_sel`. Code 0 (10-bit) gives ERR_LIMIT×64, code 1 (12-bit) gives ERR_LIMIT×16, code 2 (14-bit) gives ERR_LIMIT×4 and code 3 (16-bit) gives ERR_LIMIT. The error counts as excessive only when its magnitude is strictly greater than the threshold. Positive and negative errors are treated alike.
- R3: An excessive error lowers `health_n` only after FILT_TICKS clock edges on which `sample_tick` is 1 and the error stays excessive. Edges with `sample_tick` at 0 do not advance the window.
- R4: Any clock edge on which the error is not excessive restarts the qualification window from zero.
- R5: Once the error is no longer excessive, `health_n` returns to 1 after the next clock edge, provided the amplitudes are adequate.
- R6: Loss of signal is declared only when `sin_peak` and `cos_peak` are both below SIG_MIN. A single low channel, or a value equal to SIG_MIN, causes no fault.
- R7: Loss of reference is declared when `ref_peak` is below REF_MIN.
- R8: Loss of signal and loss of reference lower `health_n` in the same cycle as the input, with no filtering and no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | Qualification window advance strobe |
| track_err | input | ERR_W | Signed tracking error, finest-scale LSBs |
| sin_peak | input | AMP_W | Sine channel peak amplitude code |
| cos_peak | input | AMP_W | Cosine channel peak amplitude code |
| ref_peak | input | AMP_W | Reference peak amplitude code |
| res_sel | input | 2 | Resolution code, 0 to 3 for 10 to 16 bits |
| health_n | output | 1 | Health flag, 0 means fault |

## Verification
The bench builds the block with FILT_TICKS at 6, SIG_MIN and REF_MIN at 400, and ERR_W at 18. This short window lets each test reach the exact edge where the window completes, and the edge just before it, within a few cycles. It also means that a dip in the error, or a gap in the tick strobe, shifts the fault edge by a countable amount. With 18 error bits, the largest threshold plus one (6401) and its negative can both be driven on every resolution code.

// File: rtl/trk_bit_monitor.sv
module trk_bit_monitor #(
  parameter int ERR_W      = 18,
  parameter int AMP_W      = 12,
  parameter int ERR_LIMIT  = 100,
  parameter int FILT_TICKS = 50,
  parameter int SIG_MIN    = 410,
  parameter int REF_MIN    = 410
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_tick,
  input  logic signed [ERR_W-1:0] track_err,
  input  logic [AMP_W-1:0]        sin_peak,
  input  logic [AMP_W-1:0]        cos_peak,
  input  logic [AMP_W-1:0]        ref_peak,
  input  logic [1:0]              res_sel,
  output logic                    health_n
);
  localparam int CW = $clog2(FILT_TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(FILT_TICKS);
  localparam logic [AMP_W-1:0] SIG_TH = AMP_W'(SIG_MIN);
  localparam logic [AMP_W-1:0] REF_TH = AMP_W'(REF_MIN);

  logic [ERR_W:0] mag, lim;
  logic [CW-1:0]  cnt;
  logic           over, err_fault, los, lor;

  assign mag = track_err[ERR_W-1] ? -{1'b1, track_err} : {1'b0, track_err};

  always_comb begin
    case (res_sel)
      2'd0:    lim = (ERR_W+1)'(ERR_LIMIT) << 6;
      2'd1:    lim = (ERR_W+1)'(ERR_LIMIT) << 4;
      2'd2:    lim = (ERR_W+1)'(ERR_LIMIT) << 2;
      default: lim = (ERR_W+1)'(ERR_LIMIT);
    endcase
  end

  assign over = mag > lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (!over)                      cnt <= '0;
    else if (sample_tick && cnt != FULL) cnt <= cnt + 1'b1;
  end

  assign err_fault = cnt == FULL;
  assign los       = (sin_peak < SIG_TH) && (cos_peak < SIG_TH);
  assign lor       = ref_peak < REF_TH;
  assign health_n  = ~err_fault & ~los & ~lor;
endmodule

// File: rtl/trk_bit_monitor_chk.sv
module trk_bit_monitor_chk #(
  parameter int AMP_W   = 12,
  parameter int SIG_MIN = 410,
  parameter int REF_MIN = 410
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AMP_W-1:0] sin_peak,
  input logic [AMP_W-1:0] cos_peak,
  input logic [AMP_W-1:0] ref_peak,
  input logic             over,
  input logic             health_n
);
  logic sig_lost, ref_lost, amps_ok;
  assign sig_lost = (int'(sin_peak) < SIG_MIN) && (int'(cos_peak) < SIG_MIN);
  assign ref_lost = int'(ref_peak) < REF_MIN;
  assign amps_ok  = !sig_lost && !ref_lost;

  always @(posedge clk)
    if (!rst_n && amps_ok)
      assert_reset_healthy_R1: assert (health_n);

  assert_los_lowers_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sig_lost |-> !health_n);

  assert_lor_lowers_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_lost |-> !health_n);

  assert_fault_needs_history_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (amps_ok && !health_n) |-> $past(over));

  assert_clears_after_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (amps_ok && !over && $past(!over)) |-> health_n);
endmodule

bind trk_bit_monitor trk_bit_monitor_chk #(
  .AMP_W(AMP_W), .SIG_MIN(SIG_MIN), .REF_MIN(REF_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sin_peak(sin_peak), .cos_peak(cos_peak),
  .ref_peak(ref_peak), .over(over), .health_n(health_n)
);

// File: tb/tb_trk_bit_monitor.sv
module tb_trk_bit_monitor;
  localparam int ERR_W = 18, AMP_W = 12, LIMIT = 100, FT = 6, SMIN = 400, RMIN = 400;

  logic clk = 0, rst_n = 0, tick = 0;
  logic signed [ERR_W-1:0] err = '0;
  logic [AMP_W-1:0] s_pk = 12'd2000, c_pk = 12'd2000, r_pk = 12'd2000;
  logic [1:0] res = 2'd3;
  logic health_n;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  trk_bit_monitor #(.ERR_W(ERR_W), .AMP_W(AMP_W), .ERR_LIMIT(LIMIT),
    .FILT_TICKS(FT), .SIG_MIN(SMIN), .REF_MIN(RMIN)) dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(tick), .track_err(err),
    .sin_peak(s_pk), .cos_peak(c_pk), .ref_peak(r_pk), .res_sel(res),
    .health_n(health_n));

  task automatic check(input string req, input logic exp);
    #1;
    checks++;
    if (health_n !== exp) begin
      fails++;
      $display("FAIL %s: health_n=%b expected %b", req, health_n, exp);
    end
  endtask

  task automatic edges(input int n, input logic t);
    for (int i = 0; i < n; i++) begin
      tick = t;
      @(posedge clk);
      @(negedge clk);
    end
    tick = 0;
  endtask

  task automatic settle();
    err = '0;
    edges(1, 1'b1);
  endtask

  task automatic t_reset();
    check("R1 in reset", 1'b1);
    @(negedge clk) rst_n = 1;
    edges(2, 1'b1);
    check("R1 after reset", 1'b1);
  endtask

  task automatic t_threshold();
    for (int r = 0; r < 4; r++) begin
      int lim;
      lim = LIMIT << (2 * (3 - r));
      res = 2'(r);
      err = ERR_W'(lim);
      edges(FT + 2, 1'b1);
      check($sformatf("R2 res%0d at limit", r), 1'b1);
      err = -ERR_W'(lim + 1);
      edges(FT, 1'b1);
      check($sformatf("R2 res%0d negative over", r), 1'b0);
      err = '0;
      edges(1, 1'b0);
      check($sformatf("R5 res%0d clears", r), 1'b1);
    end
    res = 2'd3;
    err = ERR_W'(LIMIT + 1);
    edges(FT, 1'b1);
    check("R2 positive over", 1'b0);
    settle();
  endtask

  task automatic t_filter();
    err = ERR_W'(LIMIT + 50);
    edges(FT - 1, 1'b1);
    check("R3 window not complete", 1'b1);
    edges(1, 1'b1);
    check("R3 window complete", 1'b0);
    settle();
    err = ERR_W'(LIMIT + 50);
    for (int i = 0; i < FT - 1; i++) begin
      edges(1, 1'b1);
      edges(1, 1'b0);
    end
    check("R3 gapped ticks not complete", 1'b1);
    edges(1, 1'b1);
    check("R3 gapped ticks complete", 1'b0);
    settle();
    err = ERR_W'(LIMIT + 50);
    edges(FT - 1, 1'b1);
    err = '0;
    edges(1, 1'b1);
    err = ERR_W'(LIMIT + 50);
    edges(FT - 1, 1'b1);
    check("R4 dip restarts window", 1'b1);
    edges(1, 1'b1);
    check("R4 window after restart", 1'b0);
    settle();
    check("R5 settled", 1'b1);
  endtask

  task automatic t_amplitude();
    s_pk = 12'd100;
    check("R6 sine only low", 1'b1);
    s_pk = 12'd2000; c_pk = 12'd100;
    check("R6 cosine only low", 1'b1);
    s_pk = 12'(SMIN); c_pk = 12'(SMIN);
    check("R6 both at threshold", 1'b1);
    s_pk = 12'(SMIN - 1); c_pk = 12'(SMIN - 1);
    check("R8 both low same cycle", 1'b0);
    s_pk = 12'd2000; c_pk = 12'd2000;
    check("R8 signal restored", 1'b1);
    r_pk = 12'(RMIN);
    check("R7 reference at threshold", 1'b1);
    r_pk = 12'(RMIN - 1);
    check("R7 reference low", 1'b0);
    r_pk = 12'd2000;
    check("R7 reference restored", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_threshold();
    t_filter();
    t_amplitude();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule